// File: doc/BRIEF.md
# Sixteen-Point Inverse Asymmetric Sine Transform Datapath

This block computes the one-dimensional sixteen-point inverse asymmetric discrete sine transform used when a video decoder reconstructs residual blocks. Each accepted input is a vector of sixteen signed 32-bit coefficients. Each result is a vector of sixteen signed 32-bit samples. The arithmetic is bit-exact integer arithmetic. Rotations multiply by fixed-point cosine constants, keep the products at 64 bits, and reduce every product sum back to 32 bits with a rounded arithmetic shift.

The datapath is a four-register pipeline, one register per butterfly stage. The first stage also applies the input interleave. The last stage also applies the output reordering and the sign flips. A new vector can enter on every clock. Its result comes out exactly four clocks later, marked by a one-cycle valid pulse. The caller is expected to transpose data and feed rows or columns around this block; memory access and reconstruction are not part of it.

Top module: `iadst16_core`

## Requirements
- R1: `in_ready` is low while `rst` is high and high otherwise. A vector is taken only on a rising clock edge where `in_valid` and `in_ready` are both high.
- R2: `out_valid` is low after reset. It goes high for one cycle on the fourth rising edge after each accepting edge, counting the accepting edge as the first. Back-to-back inputs produce back-to-back results. A vector still in flight when reset is asserted never appears.
- R3: Before the first stage the lanes are regrouped as w0..w15 = c15, c0, c13, c2, c11, c4, c9, c6, c7, c8, c5, c10, c3, c12, c1, c14, where cN is input lane N.
- R4: A rotation of the pair (a, b) by indices (i, j) gives p = a·K(i) + b·K(j) and q = a·K(j) − b·K(i), with exact 64-bit products. K(k) = round(16384·cos(k·π/64)).
- R5: Every rounded reduction of a 64-bit value v returns the low 32 bits of (v + 8192) shifted right arithmetically by 14. Two's-complement wrap applies to all 32-bit sums, differences and negations.
- R6: Stage one rotates pair m = (w2m, w2m+1) by (1+4m, 31−4m) for m = 0..7, giving P2m and P2m+1. Then lane k becomes round(Pk + Pk+8) and lane k+8 becomes round(Pk − Pk+8), for k = 0..7.
- R7: Stage two maps lanes k and k+4 (k = 0..3) to the unrounded values vk + vk+4 and vk − vk+4. It forms S8,S9 = rot(v8, v9; 4, 28) and S10,S11 = rot(v10, v11; 20, 12). It forms S13,S12 = rot(v13, v12; 28, 4) and S15,S14 = rot(v15, v14; 12, 20). Lane 8+j becomes round(S8+j + S12+j) and lane 12+j becomes round(S8+j − S12+j).
- R8: Stage three works on each half b ∈ {0, 8}. Lanes b..b+3 become vb+vb+2, vb+1+vb+3, vb−vb+2, vb+1−vb+3. It forms T4,T5 = rot(vb+4, vb+5; 8, 24) and T7,T6 = rot(vb+7, vb+6; 24, 8). Lanes b+4..b+7 become round(T4+T6), round(T5+T7), round(T4−T6), round(T5−T7).
- R9: Stage four uses C = K(16). Lane 2 becomes round((v2+v3)·−C) and lane 3 becomes round((v2−v3)·C). Lane 6 becomes round((v7+v6)·C) and lane 7 becomes round((v7−v6)·C). Lane 10 becomes round((v11+v10)·C) and lane 11 becomes round((v11−v10)·C). Lane 14 becomes round((v14+v15)·−C) and lane 15 becomes round((v14−v15)·C). Each sum or difference is wrapped to 32 bits before the multiply.
- R10: Output lanes 0..15 carry the stage-four values v0, −v8, v12, −v4, v6, v14, v10, v2, v3, v11, v15, v7, v5, −v13, v9, −v1.
- R11: `out_data` holds its value in every cycle without a result, whatever is applied at the input.
- R12: Lane n of `in_coef` and of `out_data` occupies bits [32n+31 : 32n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_coef | input | 512 | Sixteen signed 32-bit coefficients |
| out_valid | output | 1 | One-cycle result marker |
| out_data | output | 512 | Sixteen signed 32-bit results |

## Verification
Single-lane impulses at the first, middle and last lanes expose a wrong interleave, output order or sign flip: a design with any of these errors puts the response on the wrong lanes or inverts it. Extreme inputs such as all lanes at the most negative value, or alternating full-scale lanes, drive the unrounded stage sums past 32 bits. They catch a design that widens instead of wrapping, or that truncates instead of rounding at the 14-bit shift. Long back-to-back streams catch stage registers that mix up neighbouring vectors. A reset in mid-flight catches a stale result leaking out after reset. Idle cycles with a changing input bus catch an output register that is not held.

// File: rtl/iadst16_pkg.sv
package iadst16_pkg;
    localparam int LANES     = 16;
    localparam int HALF      = LANES / 2;
    localparam int COEF_W    = 32;
    localparam int PROD_W    = 2 * COEF_W;
    localparam int FRAC_BITS = 14;
    localparam int CONST_W   = FRAC_BITS + 1;
    localparam int BUS_W     = LANES * COEF_W;
    localparam int LATENCY   = 4;

    typedef logic signed [COEF_W-1:0]  coef_t;
    typedef logic signed [PROD_W-1:0]  prod_t;
    typedef logic signed [CONST_W-1:0] cconst_t;
    typedef coef_t vec_t [LANES];

    // fixed-point cosine: round(2^14 * cos(k*pi/64)), only the indices used
    function automatic cconst_t cospi(input int k);
        case (k)
            1:  return 15'sd16364;
            3:  return 15'sd16207;
            4:  return 15'sd16069;
            5:  return 15'sd15893;
            7:  return 15'sd15426;
            8:  return 15'sd15137;
            9:  return 15'sd14811;
            11: return 15'sd14053;
            12: return 15'sd13623;
            13: return 15'sd13160;
            15: return 15'sd12140;
            16: return 15'sd11585;
            17: return 15'sd11003;
            19: return 15'sd9760;
            20: return 15'sd9102;
            21: return 15'sd8423;
            23: return 15'sd7005;
            24: return 15'sd6270;
            25: return 15'sd5520;
            27: return 15'sd3981;
            28: return 15'sd3196;
            29: return 15'sd2404;
            31: return 15'sd804;
            default: return '0;
        endcase
    endfunction

    function automatic prod_t mulc(input coef_t a, input cconst_t c);
        return prod_t'(a) * prod_t'(c);
    endfunction

    // rotation outputs: p = a*K(i) + b*K(j), q = a*K(j) - b*K(i)
    function automatic prod_t rot_p(input coef_t a, input coef_t b, input int i, input int j);
        return mulc(a, cospi(i)) + mulc(b, cospi(j));
    endfunction

    function automatic prod_t rot_q(input coef_t a, input coef_t b, input int i, input int j);
        return mulc(a, cospi(j)) - mulc(b, cospi(i));
    endfunction

    function automatic coef_t rnd_shift(input prod_t v);
        prod_t t;
        t = (v + (prod_t'(1) <<< (FRAC_BITS - 1))) >>> FRAC_BITS;
        return t[COEF_W-1:0];
    endfunction
endpackage

// File: rtl/iadst16_stage.sv
module iadst16_stage
    import iadst16_pkg::*;
#(
    parameter int STAGE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic v_in,
    input  vec_t d_in,
    output logic v_out,
    output vec_t d_out
);
    vec_t y;

    generate
        if (STAGE == 1) begin : g_first
            localparam int ORDER [LANES] = '{15, 0, 13, 2, 11, 4, 9, 6, 7, 8, 5, 10, 3, 12, 1, 14};
            vec_t  w;
            prod_t s [LANES];
            always_comb begin
                for (int i = 0; i < LANES; i++) w[i] = d_in[ORDER[i]];
                for (int m = 0; m < HALF; m++) begin
                    s[2*m]   = rot_p(w[2*m], w[2*m+1], 1 + 4*m, 31 - 4*m);
                    s[2*m+1] = rot_q(w[2*m], w[2*m+1], 1 + 4*m, 31 - 4*m);
                end
                for (int k = 0; k < HALF; k++) begin
                    y[k]      = rnd_shift(s[k] + s[k+HALF]);
                    y[k+HALF] = rnd_shift(s[k] - s[k+HALF]);
                end
            end
        end else if (STAGE == 2) begin : g_second
            prod_t lo [4];
            prod_t hi [4];
            always_comb begin
                lo[0] = rot_p(d_in[8],  d_in[9],  4, 28);
                lo[1] = rot_q(d_in[8],  d_in[9],  4, 28);
                lo[2] = rot_p(d_in[10], d_in[11], 20, 12);
                lo[3] = rot_q(d_in[10], d_in[11], 20, 12);
                hi[0] = rot_q(d_in[13], d_in[12], 28, 4);
                hi[1] = rot_p(d_in[13], d_in[12], 28, 4);
                hi[2] = rot_q(d_in[15], d_in[14], 12, 20);
                hi[3] = rot_p(d_in[15], d_in[14], 12, 20);
                for (int j = 0; j < 4; j++) begin
                    y[j]    = d_in[j] + d_in[j+4];
                    y[j+4]  = d_in[j] - d_in[j+4];
                    y[j+8]  = rnd_shift(lo[j] + hi[j]);
                    y[j+12] = rnd_shift(lo[j] - hi[j]);
                end
            end
        end else if (STAGE == 3) begin : g_third
            prod_t lo [2][2];
            prod_t hi [2][2];
            always_comb begin
                for (int g = 0; g < 2; g++) begin
                    lo[g][0] = rot_p(d_in[8*g+4], d_in[8*g+5], 8, 24);
                    lo[g][1] = rot_q(d_in[8*g+4], d_in[8*g+5], 8, 24);
                    hi[g][0] = rot_q(d_in[8*g+7], d_in[8*g+6], 24, 8);
                    hi[g][1] = rot_p(d_in[8*g+7], d_in[8*g+6], 24, 8);
                    y[8*g]   = d_in[8*g]   + d_in[8*g+2];
                    y[8*g+1] = d_in[8*g+1] + d_in[8*g+3];
                    y[8*g+2] = d_in[8*g]   - d_in[8*g+2];
                    y[8*g+3] = d_in[8*g+1] - d_in[8*g+3];
                    y[8*g+4] = rnd_shift(lo[g][0] + hi[g][0]);
                    y[8*g+5] = rnd_shift(lo[g][1] + hi[g][1]);
                    y[8*g+6] = rnd_shift(lo[g][0] - hi[g][0]);
                    y[8*g+7] = rnd_shift(lo[g][1] - hi[g][1]);
                end
            end
        end else begin : g_fourth
            localparam int OPA  [4] = '{2, 7, 11, 14};
            localparam int OPB  [4] = '{3, 6, 10, 15};
            localparam int SDST [4] = '{2, 6, 10, 14};
            localparam int DDST [4] = '{3, 7, 11, 15};
            localparam int SNEG [4] = '{1, 0, 0, 1};
            localparam int SRC  [LANES] = '{0, 8, 12, 4, 6, 14, 10, 2, 3, 11, 15, 7, 5, 13, 9, 1};
            localparam int FLIP [LANES] = '{0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1};
            vec_t    w;
            coef_t   sm [4];
            coef_t   df [4];
            cconst_t c16;
            always_comb begin
                c16 = cospi(16);
                w   = d_in;
                for (int p = 0; p < 4; p++) begin
                    sm[p] = d_in[OPA[p]] + d_in[OPB[p]];
                    df[p] = d_in[OPA[p]] - d_in[OPB[p]];
                    w[SDST[p]] = rnd_shift(mulc(sm[p], (SNEG[p] != 0) ? -c16 : c16));
                    w[DDST[p]] = rnd_shift(mulc(df[p], c16));
                end
                for (int i = 0; i < LANES; i++)
                    y[i] = (FLIP[i] != 0) ? -w[SRC[i]] : w[SRC[i]];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
            d_out <= '{default: '0};
        end else begin
            v_out <= v_in;
            if (v_in) d_out <= y;
        end
    end

    // R2: each stage advances the valid marker by exactly one clock
    p_valid_step_r2: assert property (@(posedge clk) disable iff (rst) v_in |=> v_out);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst) !v_in |=> !v_out);
endmodule

// File: rtl/iadst16_core.sv
module iadst16_core
    import iadst16_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BUS_W-1:0] in_coef,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_data
);
    logic pv [LATENCY+1];
    vec_t pd [LATENCY+1];

    assign in_ready = !rst;
    assign pv[0]    = in_valid && in_ready;

    always_comb begin
        for (int i = 0; i < LANES; i++) pd[0][i] = in_coef[i*COEF_W +: COEF_W];
    end

    generate
        for (genvar s = 0; s < LATENCY; s++) begin : g_pipe
            iadst16_stage #(.STAGE(s + 1)) u_stage (
                .clk  (clk),
                .rst  (rst),
                .v_in (pv[s]),
                .d_in (pd[s]),
                .v_out(pv[s+1]),
                .d_out(pd[s+1])
            );
        end
    endgenerate

    assign out_valid = pv[LATENCY];

    always_comb begin
        for (int i = 0; i < LANES; i++) out_data[i*COEF_W +: COEF_W] = pd[LATENCY][i];
    end

    // R2: no result straight after reset, and every result traces back to an accept
    p_quiet_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pv[0], LATENCY));
    // R11: output bus is held when the last stage receives nothing
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !pv[LATENCY-1] |=> $stable(out_data));
    // R5: zero coefficients round to zero through every stage
    p_zero_maps_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $past(pv[0] && (in_coef == '0), LATENCY) |-> (out_data == '0));
endmodule

// File: tb/iadst16_core_test.sv
`timescale 1ns/1ps
module iadst16_core_test;
    localparam int NL = 16;
    localparam int W  = 32 * NL;
    localparam int NS = 12;
    localparam int NT = 10;
    // pattern word: [31:24] kind, [23:0] argument
    localparam logic [31:0] TABLE [NT] = '{
        32'h00_000000, 32'h00_00000F, 32'h00_000007, 32'h01_000005, 32'h02_000400,
        32'h03_00000B, 32'h03_00001D, 32'h04_000005, 32'h05_000000, 32'h06_000000
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_coef = '0;
    logic         in_ready;
    logic         out_valid;
    logic [W-1:0] out_data;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iadst16_core uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int kc(int k);
        return $rtoi(16384.0 * $cos(3.141592653589793 * k / 64.0) + 0.5);
    endfunction
    function automatic int rsh(longint v);
        longint t = (v + 64'sd8192) >>> 14;
        return int'(t);
    endfunction
    function automatic longint pm(int a, int b, int i, int j);
        return longint'(a) * kc(i) + longint'(b) * kc(j);
    endfunction
    function automatic longint qm(int a, int b, int i, int j);
        return longint'(a) * kc(j) - longint'(b) * kc(i);
    endfunction
    function automatic int hb(int v, int c);
        return rsh(longint'(v) * c);
    endfunction

    function automatic logic [W-1:0] golden(logic [W-1:0] vi);
        int c[16], x[16], t[16], o[16];
        longint s[16];
        int c16;
        logic [W-1:0] vo;
        for (int i = 0; i < NL; i++) c[i] = vi[i*32 +: 32];
        x = '{c[15], c[0], c[13], c[2], c[11], c[4], c[9], c[6],
              c[7], c[8], c[5], c[10], c[3], c[12], c[1], c[14]};
        for (int m = 0; m < 8; m++) begin
            s[2*m]   = pm(x[2*m], x[2*m+1], 1 + 4*m, 31 - 4*m);
            s[2*m+1] = qm(x[2*m], x[2*m+1], 1 + 4*m, 31 - 4*m);
        end
        for (int k = 0; k < 8; k++) begin
            t[k]   = rsh(s[k] + s[k+8]);
            t[k+8] = rsh(s[k] - s[k+8]);
        end
        x = t;
        for (int k = 0; k < 4; k++) begin
            t[k]   = x[k] + x[k+4];
            t[k+4] = x[k] - x[k+4];
        end
        s[8]  = pm(x[8], x[9], 4, 28);    s[9]  = qm(x[8], x[9], 4, 28);
        s[10] = pm(x[10], x[11], 20, 12); s[11] = qm(x[10], x[11], 20, 12);
        s[13] = pm(x[13], x[12], 28, 4);  s[12] = qm(x[13], x[12], 28, 4);
        s[15] = pm(x[15], x[14], 12, 20); s[14] = qm(x[15], x[14], 12, 20);
        for (int k = 0; k < 4; k++) begin
            t[8+k]  = rsh(s[8+k] + s[12+k]);
            t[12+k] = rsh(s[8+k] - s[12+k]);
        end
        x = t;
        for (int b = 0; b < 16; b += 8) begin
            t[b]   = x[b] + x[b+2];
            t[b+1] = x[b+1] + x[b+3];
            t[b+2] = x[b] - x[b+2];
            t[b+3] = x[b+1] - x[b+3];
            s[b+4] = pm(x[b+4], x[b+5], 8, 24); s[b+5] = qm(x[b+4], x[b+5], 8, 24);
            s[b+7] = pm(x[b+7], x[b+6], 24, 8); s[b+6] = qm(x[b+7], x[b+6], 24, 8);
            t[b+4] = rsh(s[b+4] + s[b+6]);
            t[b+5] = rsh(s[b+5] + s[b+7]);
            t[b+6] = rsh(s[b+4] - s[b+6]);
            t[b+7] = rsh(s[b+5] - s[b+7]);
        end
        x = t;
        c16 = kc(16);
        t[2]  = hb(x[2] + x[3], -c16);   t[3]  = hb(x[2] - x[3], c16);
        t[6]  = hb(x[7] + x[6], c16);    t[7]  = hb(x[7] - x[6], c16);
        t[10] = hb(x[11] + x[10], c16);  t[11] = hb(x[11] - x[10], c16);
        t[14] = hb(x[14] + x[15], -c16); t[15] = hb(x[14] - x[15], c16);
        o = '{t[0], -t[8], t[12], -t[4], t[6], t[14], t[10], t[2],
              t[3], t[11], t[15], t[7], t[5], -t[13], t[9], -t[1]};
        for (int i = 0; i < NL; i++) vo[i*32 +: 32] = o[i];
        return vo;
    endfunction

    function automatic logic [W-1:0] make_vec(logic [31:0] pat);
        logic [W-1:0] v = '0;
        int sd = int'(pat[23:0]);
        case (pat[31:24])
            8'd0: v[pat[3:0]*32 +: 32] = 32'sd1000;
            8'd1: v[pat[3:0]*32 +: 32] = 32'h7FFF_FFFF;
            8'd2: for (int i = 0; i < NL; i++) v[i*32 +: 32] = {8'h00, pat[23:0]};
            8'd3: for (int i = 0; i < NL; i++) v[i*32 +: 32] = $random(sd);
            8'd4: for (int i = 0; i < NL; i++) v[i*32 +: 32] = $random(sd) >>> 15;
            8'd5: for (int i = 0; i < NL; i++) v[i*32 +: 32] = i[0] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            default: for (int i = 0; i < NL; i++) v[i*32 +: 32] = 32'h8000_0000;
        endcase
        return v;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        int bad = -1;
        checks++;
        for (int i = NL - 1; i >= 0; i--) if (act[i*32 +: 32] !== exp[i*32 +: 32]) bad = i;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: lane %0d got %0d expected %0d", tag, bad,
                     $signed(act[bad*32 +: 32]), $signed(exp[bad*32 +: 32]));
        end
    endtask

    task automatic run_one(logic [W-1:0] v);
        logic [W-1:0] e = golden(v);
        @(negedge clk); in_valid = 1'b1; in_coef = v;
        @(negedge clk); in_valid = 1'b0; in_coef = ~v;
        @(negedge clk);
        @(negedge clk); check_bit("R2 no result before latency", out_valid, 1'b0);
        @(negedge clk); check_bit("R2 result after four edges", out_valid, 1'b1);
        check_vec("R3 R4 R5 R6 R7 R8 R9 R10 R12 table vector", out_data, e);
        @(negedge clk); check_bit("R2 single valid pulse", out_valid, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] sv [NS];
        logic [W-1:0] se [NS];
        int sd = 77;

        // reset: input offered but must be ignored
        in_valid = 1'b1;
        in_coef  = make_vec(32'h03_000063);
        repeat (4) @(negedge clk);
        check_bit("R1 ready low in reset", in_ready, 1'b0);
        check_bit("R2 valid low in reset", out_valid, 1'b0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk); check_bit("R1 ready high after reset", in_ready, 1'b1);
        repeat (4) @(negedge clk);
        check_bit("R1 nothing taken during reset", out_valid, 1'b0);

        // table of patterns
        for (int n = 0; n < NT; n++) run_one(make_vec(TABLE[n]));

        // back-to-back stream
        for (int n = 0; n < NS; n++) begin
            for (int i = 0; i < NL; i++) sv[n][i*32 +: 32] = $random(sd);
            if (n == 3) sv[n] = make_vec(32'h06_000000);
            se[n] = golden(sv[n]);
        end
        for (int c = 0; c < NS + 4; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                check_bit("R2 stream valid", out_valid, 1'b1);
                check_vec("R2 R10 stream data", out_data, se[c-4]);
            end
            if (c < NS) begin in_valid = 1'b1; in_coef = sv[c]; end
            else begin in_valid = 1'b0; end
        end

        // hold: idle input with changing data
        for (int k = 0; k < 5; k++) begin
            in_coef = make_vec(32'h03_000100 + k);
            @(negedge clk);
            check_bit("R11 idle valid low", out_valid, 1'b0);
            check_vec("R11 output held", out_data, se[NS-1]);
        end

        // reset while a vector is in flight
        in_valid = 1'b1; in_coef = make_vec(32'h01_000009);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check_bit("R2 flushed by reset", out_valid, 1'b0);
        end

        // small-range impulse on a middle lane after the flush
        run_one(make_vec(32'h00_00000A));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule